// File: doc/BRIEF.md
# Priority Exception Pend Controller

This block tracks which exception sources are waiting, which are running, and which one the processor should run next. Each source has a pending flag, an enable bit and an 8-bit priority, where a smaller number is more urgent. A source becomes pending when its hardware request line is high in a cycle, or when software sets its flag through the register port. One source is the deferred source. Software can pend it through a dedicated bit of the status register. When it is given priority 0xFF, it runs only after every more urgent handler has finished.

The block offers the most urgent eligible source to a CPU model through `exc_valid`/`exc_num`. A source is eligible when it is pending, enabled, not already running and not blocked by the global mask. It is offered only when it is strictly more urgent than the running exception. The CPU takes the offer with `exc_take` and ends the current handler with `exc_ret`. On a return, a pending source that beats the level left behind is activated in the same cycle, without passing through a less urgent level (a tail-chain). The 9-bit active number reads zero in thread mode, so software can tell whether it is running inside a handler.

Top module: `excpend_ctrl`

## Requirements
- R1: After synchronous reset, all of the following are zero: pending, active, enable, mask, priorities, `act_num`, `tail_chain`, `exc_valid` and `reg_rdata`.
- R2: A read of address 0 (status) returns the active number in bits [8:0], which is 0 in thread mode. The read data appears on `reg_rdata` one cycle after the address.
- R3: A write to address 0 with bit 28 set pends the deferred source (index N-1, number N). A write with bit 28 clear has no effect on it. Status bit 28 reads that source's pending flag.
- R4: A high `irq_req[i]` in a cycle sets pending flag i at the next edge. A write to address 1 sets every pending flag whose data bit is one. Neither path depends on the enable bits. Address 1 reads the pending vector.
- R5: `exc_valid` is high, with `exc_num` = index+1, only for a source that is pending, enabled (address 2, bit per source), not active and not masked. When `exc_valid` is low, `exc_num` is 0 and a take is ignored.
- R6: Among eligible sources with equal priority, the lowest index wins.
- R7: A take while `exc_valid` is high (with no effective return in the same cycle) clears that source's pending flag, marks it active and sets `act_num` to `exc_num` at the next edge.
- R8: A source preempts the running exception only with a numerically lower priority. Equal priority waits. Priority i is at address 4+i, bits [7:0].
- R9: On `exc_ret`, if an eligible source beats the best remaining active level (thread level counts as beyond 0xFF), it becomes active at that edge. `act_num` moves directly to its number and `tail_chain` pulses high for one cycle.
- R10: On `exc_ret` with no such source, `act_num` returns to the most urgent still-active exception, or to 0. `tail_chain` stays low.
- R11: Writing address 3 with bit 0 set raises the global mask, and bit 1 alone clears it. While the mask is raised, nothing is offered and pending flags are kept.
- R12: The deferred source at priority 0xFF is preempted by any more urgent eligible request while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N | Hardware request lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| exc_take | input | 1 | CPU accepts the offered exception |
| exc_ret | input | 1 | CPU returns from the current handler |
| exc_valid | output | 1 | An exception may preempt now |
| exc_num | output | 9 | Number of the offered exception |
| act_num | output | 9 | Number of the running exception, 0 in thread mode |
| tail_chain | output | 1 | One-cycle pulse when a return chained into a new handler |

## Verification
The assertions check every cycle that nothing is offered under the mask, that an offered number is in range, that a take lands its number in `act_num`, that requests always leave their pending flag set, and that a chain pulse follows a return and never lands in thread mode. The relative order of priorities cannot be seen by those properties. Equal-priority waiting, lowest-index tie-breaks, unwinding nested handlers back to the preempted one, and the deferred source running last are shown only by the bench's scenarios, which are checked against its behavioural model.

// File: rtl/excpend_pkg.sv
package excpend_pkg;
  localparam int NUM_W          = 9;   // width of exception number fields
  localparam int STAT_DEFER_BIT = 28;  // status bit that pends the deferred source
  localparam int A_STAT  = 0;
  localparam int A_PEND  = 1;
  localparam int A_EN    = 2;
  localparam int A_MASK  = 3;
  localparam int A_PRIO0 = 4;
  typedef logic [NUM_W-1:0] exc_num_t;
endpackage

// File: rtl/prio_pick.sv
// Finds the most urgent requester; ties resolve to the lowest index.
module prio_pick #(
  parameter int N  = 8,
  parameter int PW = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0][PW-1:0] prio,
  output logic                 hit,
  output logic [IDX_W-1:0]     idx,
  output logic [PW-1:0]        best
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!hit || prio[i] < best)) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        best = prio[i];
      end
    end
  end
endmodule

// File: rtl/exc_cfg_regs.sv
// Enable bits, per-source priorities and the global mask.
module exc_cfg_regs
  import excpend_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 8,
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [31:0]          wdata,
  output logic [N-1:0]         en_q,
  output logic [N-1:0][PW-1:0] prio_q,
  output logic                 mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mask_q <= 1'b0;
    end else if (wr) begin
      if (addr == AW'(A_EN)) en_q <= wdata[N-1:0];
      if (addr == AW'(A_MASK)) begin
        if (wdata[0])      mask_q <= 1'b1;
        else if (wdata[1]) mask_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)                                    prio_q[g] <= '0;
      else if (wr && addr == AW'(A_PRIO0 + g))    prio_q[g] <= wdata[PW-1:0];
    end
  end
endmodule

// File: rtl/excpend_ctrl.sv
module excpend_ctrl
  import excpend_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 8,
  parameter int AW = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int LVL_W = PW + 1,
  localparam int DEFER_IDX = N - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   irq_req,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           exc_take,
  input  logic           exc_ret,
  output logic           exc_valid,
  output logic [8:0]     exc_num,
  output logic [8:0]     act_num,
  output logic           tail_chain
);
  localparam logic [LVL_W-1:0] THREAD_LVL = {1'b1, {PW{1'b0}}};

  logic [N-1:0]         pend_q, act_q, en_q;
  logic [N-1:0][PW-1:0] prio_q;
  logic                 mask_q;
  exc_num_t             act_num_q;
  logic                 chain_q;
  logic [31:0]          rdata_q;
  wire                  unused_wdata = ^reg_wdata;

  exc_cfg_regs #(.N(N), .PW(PW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en_q(en_q), .prio_q(prio_q), .mask_q(mask_q)
  );

  // Eligible pending sources and their winner
  logic [N-1:0]     elig;
  logic             w_hit, c_hit, r_hit;
  logic [IDX_W-1:0] w_idx, c_idx, r_idx;
  logic [PW-1:0]    w_prio, c_prio, r_prio;
  assign elig = pend_q & en_q & ~act_q & {N{~mask_q}};

  prio_pick #(.N(N), .PW(PW)) u_win (.req(elig), .prio(prio_q),
    .hit(w_hit), .idx(w_idx), .best(w_prio));

  // Running level and the level left after a return
  logic [N-1:0] cur_oh, rem_act, w_oh;
  prio_pick #(.N(N), .PW(PW)) u_cur (.req(act_q), .prio(prio_q),
    .hit(c_hit), .idx(c_idx), .best(c_prio));
  assign cur_oh  = c_hit ? (N'(1) << c_idx) : '0;
  assign rem_act = act_q & ~cur_oh;
  prio_pick #(.N(N), .PW(PW)) u_rem (.req(rem_act), .prio(prio_q),
    .hit(r_hit), .idx(r_idx), .best(r_prio));

  logic [LVL_W-1:0] cur_lvl, rem_lvl, win_lvl;
  assign cur_lvl = c_hit ? {1'b0, c_prio} : THREAD_LVL;
  assign rem_lvl = r_hit ? {1'b0, r_prio} : THREAD_LVL;
  assign win_lvl = {1'b0, w_prio};
  assign w_oh    = N'(1) << w_idx;

  logic preempt, chain_ok, do_ret, do_take;
  assign preempt  = w_hit && (win_lvl < cur_lvl);
  assign chain_ok = w_hit && (win_lvl < rem_lvl);
  assign do_ret   = exc_ret && c_hit;
  assign do_take  = exc_take && !do_ret && preempt;

  // Next active set, active number and pending clears
  logic [N-1:0] act_nxt, clr, set;
  exc_num_t     num_nxt;
  always_comb begin
    act_nxt = act_q;
    clr     = '0;
    num_nxt = act_num_q;
    if (do_ret) begin
      act_nxt = rem_act;
      num_nxt = r_hit ? exc_num_t'(r_idx) + 1'b1 : '0;
      if (chain_ok) begin
        act_nxt = rem_act | w_oh;
        clr     = w_oh;
        num_nxt = exc_num_t'(w_idx) + 1'b1;
      end
    end else if (do_take) begin
      act_nxt = act_q | w_oh;
      clr     = w_oh;
      num_nxt = exc_num_t'(w_idx) + 1'b1;
    end
  end

  always_comb begin
    set = irq_req;
    if (reg_wr && reg_addr == AW'(A_PEND)) set = set | reg_wdata[N-1:0];
    if (reg_wr && reg_addr == AW'(A_STAT) && reg_wdata[STAT_DEFER_BIT])
      set[DEFER_IDX] = 1'b1;
  end

  // Read mux
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(A_STAT)) begin
      rd_mux[NUM_W-1:0]     = act_num_q;
      rd_mux[STAT_DEFER_BIT] = pend_q[DEFER_IDX];
    end else if (reg_addr == AW'(A_PEND)) rd_mux[N-1:0] = pend_q;
    else if (reg_addr == AW'(A_EN))       rd_mux[N-1:0] = en_q;
    else if (reg_addr == AW'(A_MASK))     rd_mux[0]     = mask_q;
    for (int i = 0; i < N; i++)
      if (reg_addr == AW'(A_PRIO0 + i)) rd_mux[PW-1:0] = prio_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      act_q     <= '0;
      act_num_q <= '0;
      chain_q   <= 1'b0;
      rdata_q   <= '0;
    end else begin
      pend_q    <= (pend_q & ~clr) | set;
      act_q     <= act_nxt;
      act_num_q <= num_nxt;
      chain_q   <= do_ret && chain_ok;
      rdata_q   <= rd_mux;
    end
  end

  assign exc_valid  = preempt;
  assign exc_num    = preempt ? exc_num_t'(w_idx) + 1'b1 : '0;
  assign act_num    = act_num_q;
  assign tail_chain = chain_q;
  assign reg_rdata  = rdata_q;
endmodule

// File: rtl/excpend_chk.sv
module excpend_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] irq_req,
  input logic         exc_take,
  input logic         exc_ret,
  input logic         exc_valid,
  input logic [8:0]   exc_num,
  input logic [8:0]   act_num,
  input logic         tail_chain,
  input logic [N-1:0] pend_q,
  input logic         mask_q
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (act_num == 9'd0 && !tail_chain));

  // R5
  offer_range_chk: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_num != 9'd0 && exc_num <= 9'(N)));

  // R7
  take_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_take && exc_valid && !exc_ret) |=> (act_num == $past(exc_num)));

  // R9
  chain_not_thread_chk: assert property (@(posedge clk) disable iff (rst)
    tail_chain |-> (act_num != 9'd0));

  // R9
  chain_after_ret_chk: assert property (@(posedge clk) disable iff (rst)
    tail_chain |-> $past(exc_ret));

  // R11
  mask_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    mask_q |-> !exc_valid);

  // R4
  req_pends_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req != '0) |=> ((pend_q & $past(irq_req)) == $past(irq_req)));
endmodule

bind excpend_ctrl excpend_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .exc_take(exc_take), .exc_ret(exc_ret),
  .exc_valid(exc_valid), .exc_num(exc_num), .act_num(act_num),
  .tail_chain(tail_chain), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/sim_excpend_ctrl.sv
module sim_excpend_ctrl;
  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam int PW = 8;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_req = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic exc_take = 1'b0, exc_ret = 1'b0;
  logic exc_valid, tail_chain;
  logic [8:0] exc_num, act_num;

  always #(CLK_P/2) clk = ~clk;

  excpend_ctrl #(.N(N), .PW(PW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_take(exc_take), .exc_ret(exc_ret),
    .exc_valid(exc_valid), .exc_num(exc_num), .act_num(act_num), .tail_chain(tail_chain)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string phase = "R1";

  task automatic chk(bit ok, string tag, string what, longint actual, longint expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_pend[N], m_act[N], m_en[N];
  int m_prio[N];
  bit m_mask, m_chain;
  int m_num;
  logic [31:0] m_rdata;

  function automatic int best_act();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_act[i] && (b < 0 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  function automatic int lvl_of(int i);
    return (i < 0) ? 256 : m_prio[i];
  endfunction

  function automatic int winner();
    int b = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && m_en[i] && !m_act[i] && !m_mask && (b < 0 || m_prio[i] < m_prio[b])) b = i;
    return b;
  endfunction

  function automatic bit exp_valid();
    int w = winner();
    return (w >= 0) && (m_prio[w] < lvl_of(best_act()));
  endfunction

  function automatic logic [31:0] read_model(int a);
    logic [31:0] r = '0;
    if (a == 0) begin r[8:0] = 9'(m_num); r[28] = m_pend[N-1]; end
    else if (a == 1) for (int i = 0; i < N; i++) r[i] = m_pend[i];
    else if (a == 2) for (int i = 0; i < N; i++) r[i] = m_en[i];
    else if (a == 3) r[0] = m_mask;
    else if (a >= 4 && a < 4 + N) r[7:0] = 8'(m_prio[a-4]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_act[i] = 0; m_en[i] = 0; m_prio[i] = 0; end
      m_mask = 0; m_chain = 0; m_num = 0; m_rdata = '0;
    end else begin
      int cur, w, r;
      bit v;
      cur = best_act();
      w = winner();
      v = exp_valid();
      m_rdata = read_model(int'(reg_addr));
      m_chain = 0;
      if (exc_ret && cur >= 0) begin
        m_act[cur] = 0;
        r = best_act();
        if (w >= 0 && m_prio[w] < lvl_of(r)) begin
          m_act[w] = 1; m_pend[w] = 0; m_chain = 1; m_num = w + 1;
        end else m_num = (r < 0) ? 0 : r + 1;
      end else if (exc_take && v) begin
        m_act[w] = 1; m_pend[w] = 0; m_num = w + 1;
      end
      for (int i = 0; i < N; i++) if (irq_req[i]) m_pend[i] = 1;
      if (reg_wr) begin
        if (reg_addr == 0 && reg_wdata[28]) m_pend[N-1] = 1;
        if (reg_addr == 1) for (int i = 0; i < N; i++) if (reg_wdata[i]) m_pend[i] = 1;
        if (reg_addr == 2) for (int i = 0; i < N; i++) m_en[i] = reg_wdata[i];
        if (reg_addr == 3) begin
          if (reg_wdata[0]) m_mask = 1; else if (reg_wdata[1]) m_mask = 0;
        end
        if (reg_addr >= 4 && reg_addr < 4 + N) m_prio[reg_addr-4] = int'(reg_wdata[7:0]);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ev;
      int en;
      ev = exp_valid();
      en = ev ? winner() + 1 : 0;
      chk(exc_valid == ev, phase, "model exc_valid", exc_valid, ev);
      chk(exc_num == 9'(en), phase, "model exc_num", exc_num, en);
      chk(act_num == 9'(m_num), phase, "model act_num", act_num, m_num);
      chk(tail_chain == m_chain, phase, "model tail_chain", tail_chain, m_chain);
      chk(reg_rdata == m_rdata, phase, "model rdata", reg_rdata, m_rdata);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<50000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = AW'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic irq(logic [N-1:0] m);
    irq_req = m;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic take();
    exc_take = 1;
    @(negedge clk);
    exc_take = 0;
  endtask

  task automatic ret();
    exc_ret = 1;
    @(negedge clk);
    exc_ret = 0;
  endtask

  task automatic see(string tag, bit v, int num, int act);
    chk(exc_valid == v, tag, "exc_valid", exc_valid, v);
    chk(exc_num == 9'(num), tag, "exc_num", exc_num, num);
    chk(act_num == 9'(act), tag, "act_num", act_num, act);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    phase = "R1";
    see("R1", 0, 0, 0);
    chk(tail_chain == 0, "R1", "tail_chain", tail_chain, 0);
    rd(0, d); chk(d == 0, "R1", "status after reset", d, 0);

    phase = "R8";
    wr(4, 32'h40); wr(5, 32'h40); wr(6, 32'h10); wr(7, 32'h80); wr(11, 32'hFF);
    wr(2, 32'hFF);
    rd(6, d); chk(d == 32'h10, "R8", "priority readback", d, 32'h10);

    phase = "R6";
    irq(8'h01); wr(1, 32'h2);          // R4: hardware and software pend
    see("R6", 1, 1, 0);
    rd(1, d); chk(d == 32'h3, "R4", "pending vector", d, 32'h3);

    phase = "R7";
    take();
    see("R7", 0, 0, 1);                // R8: src1 equal priority waits
    rd(1, d); chk(d == 32'h2, "R7", "pending cleared on take", d, 32'h2);

    phase = "R8";
    irq(8'h04);
    see("R8", 1, 3, 1);
    take();
    see("R8", 0, 0, 3);
    rd(0, d); chk(d[8:0] == 9'd3, "R2", "status active number", d[8:0], 3);

    phase = "R3";
    wr(0, 32'h1000_0000);
    rd(0, d); chk(d == 32'h1000_0003, "R3", "deferred pend bit", d, 32'h1000_0003);
    chk(exc_valid == 0, "R12", "deferred not offered", exc_valid, 0);

    phase = "R10";
    ret();
    chk(act_num == 9'd1, "R10", "unwind to preempted", act_num, 1);
    chk(tail_chain == 0, "R10", "no chain", tail_chain, 0);

    phase = "R9";
    ret();
    chk(act_num == 9'd2, "R9", "chain to equal-prio waiter", act_num, 2);
    chk(tail_chain == 1, "R9", "chain pulse", tail_chain, 1);
    ret();
    chk(act_num == 9'd8, "R9", "chain to deferred", act_num, 8);
    chk(tail_chain == 1, "R9", "chain pulse deferred", tail_chain, 1);
    rd(0, d); chk(d == 32'h8, "R2", "status in deferred", d, 32'h8);

    phase = "R12";
    irq(8'h08);
    see("R12", 1, 4, 8);
    take();
    chk(act_num == 9'd4, "R12", "preempted deferred", act_num, 4);
    ret();
    chk(act_num == 9'd8, "R10", "back to deferred", act_num, 8);
    ret();
    chk(act_num == 9'd0, "R10", "back to thread", act_num, 0);

    phase = "R11";
    wr(3, 32'h1);
    irq(8'h01);
    see("R11", 0, 0, 0);
    rd(1, d); chk(d == 32'h1, "R11", "pending kept under mask", d, 32'h1);
    rd(3, d); chk(d == 32'h1, "R11", "mask readback", d, 32'h1);
    wr(3, 32'h2);
    see("R11", 1, 1, 0);
    take(); ret();

    phase = "R3";
    wr(0, 32'h0);
    rd(0, d); chk(d == 32'h0, "R3", "bit28 clear no pend", d, 32'h0);

    phase = "R5";
    wr(2, 32'hFE);
    irq(8'h01);
    see("R5", 0, 0, 0);
    take();
    chk(act_num == 9'd0, "R5", "take ignored", act_num, 0);
    wr(2, 32'hFF);
    see("R5", 1, 1, 0);
    take(); ret();
    see("R5", 0, 0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule